// File: doc/BRIEF.md
# Burst-Capable Bus Memory Slave

This block is a small memory target on a Wishbone B3 style bus. It holds a parameterised array of words and answers single accesses and bursts. Reads and writes are both supported, and writes honour per-byte lane enables. The master tells the slave what follows each beat through a three-bit cycle type code. The slave uses registered feedback: the first beat of any access waits one cycle for acknowledge. After that, a burst produces one beat on every cycle.

The master can stall a burst by lowering strobe while cycle stays high. When it does, the slave keeps the pending beat as it is. Acknowledge stays high, the presented word does not change, nothing is written and the internal address does not move. When strobe rises again, the master takes the beat that is already on the data output. Lowering cycle abandons the transfer on the next clock edge.

Top module: `bus_burst_slave`

## Requirements
- R1: While acknowledge is low, including right after reset, the read data output is all zeros and acknowledge is low after reset.
- R2: With acknowledge low, a cycle where cyc and stb are both high raises acknowledge on the next cycle. The data output then shows the word at the address sampled with that request. Acknowledge never rises without such a request.
- R3: A beat completes on a cycle where cyc, stb and acknowledge are all high. If the cycle type on that beat is 3'b000 (single access) or 3'b111 (last beat), acknowledge is low on the next cycle. Any other unlisted code is treated the same way.
- R4: A completing beat with cycle type 3'b010 (incrementing burst) keeps acknowledge high. The next beat uses the word address plus one, wrapping modulo the array depth.
- R5: A completing beat with cycle type 3'b001 (fixed-address burst) keeps acknowledge high. The next beat uses the same word address.
- R6: While acknowledge is high and stb is low with cyc high, the beat is not consumed. On the next cycle acknowledge stays high, the data output is unchanged, the address does not advance and the word is not written.
- R7: A cycle with cyc low makes acknowledge low on the next cycle. A following request starts afresh with the one-cycle latency of R2.
- R8: A write (we high) stores dat_i into the current beat's word only on a completing beat. Only bytes whose sel bit is set are stored: bit k of sel covers data bits 8k+7 down to 8k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Beat strobe from master |
| we_i | input | 1 | Write enable |
| adr_i | input | ADDR_W | Word address, sampled on a first beat |
| dat_i | input | DATA_W | Write data |
| sel_i | input | DATA_W/8 | Byte lane enables |
| cti_i | input | 3 | Cycle type of the current beat |
| dat_o | output | DATA_W | Read data, valid with ack_o |
| ack_o | output | 1 | Beat acknowledge |

## Verification
The bound checker tests the acknowledge protocol on every cycle. It covers the one-cycle first-beat latency, acknowledge never starting without a request, acknowledge staying high or falling after each completing beat according to cycle type, the frozen beat during a strobe-low wait, the clear after cyc falls, and zero data while acknowledge is low. Data values can only be shown by the bench's scenarios against its own memory model. These include the incremented and wrapping burst addresses, repeated words in fixed-address bursts, byte-lane merging, and the fact that a stalled write beat leaves memory untouched.

// File: rtl/bus_burst_pkg.sv
// Shared definitions for the burst memory slave.
// Assumes: cycle type codes follow the bus convention for single,
// fixed-address burst, incrementing burst and last beat.
package bus_burst_pkg;

    typedef enum logic [2:0] {
        CTI_SINGLE = 3'b000,
        CTI_FIXED  = 3'b001,
        CTI_INCR   = 3'b010,
        CTI_LAST   = 3'b111
    } cti_e;

endpackage

// File: rtl/burst_word_store.sv
// Word array with byte-lane writes and an asynchronous read port.
// Assumes: one write per cycle, read and write share one address.
module burst_word_store #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_lanes,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] words [DEPTH];

    // Clear on reset, then merge enabled byte lanes on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (wr_en) begin
            for (int b = 0; b < LANES; b++) begin
                if (wr_lanes[b]) begin
                    words[addr][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end

    // Present the addressed word.
    always_comb begin
        rd_data = words[addr];
    end

endmodule

// File: rtl/burst_beat_ctrl.sv
// Beat sequencer: raises acknowledge one cycle after a new request and
// keeps it high through bursts. It holds the beat while strobe is low and
// steps the word address on completed incrementing beats.
// Assumes: the master holds cycle type stable with each beat.
module burst_beat_ctrl
    import bus_burst_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc,
    input  logic              stb,
    input  logic [ADDR_W-1:0] adr,
    input  logic [2:0]        cti,
    output logic              ack,
    output logic              beat_done,
    output logic [ADDR_W-1:0] beat_addr
);
    logic              ack_q;
    logic [ADDR_W-1:0] addr_q;

    // Track the acknowledge state and the current beat's word address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            addr_q <= '0;
        end else if (!cyc) begin
            ack_q <= 1'b0;
        end else if (!ack_q) begin
            if (stb) begin
                ack_q  <= 1'b1;
                addr_q <= adr;
            end
        end else if (stb) begin
            case (cti)
                CTI_FIXED: ack_q  <= 1'b1;
                CTI_INCR:  addr_q <= addr_q + 1'b1;
                default:   ack_q  <= 1'b0;
            endcase
        end
    end

    // Beat is consumed only with all three handshake signals high.
    always_comb begin
        ack       = ack_q;
        beat_done = cyc & stb & ack_q;
        beat_addr = addr_q;
    end

endmodule

// File: rtl/bus_burst_slave.sv
// Top level of the burst memory slave: joins the beat sequencer and the
// word array, and gates read data with acknowledge.
// Assumes: a single master; DATA_W is a multiple of 8.
module bus_burst_slave #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cyc_i,
    input  logic                stb_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   adr_i,
    input  logic [DATA_W-1:0]   dat_i,
    input  logic [DATA_W/8-1:0] sel_i,
    input  logic [2:0]          cti_i,
    output logic [DATA_W-1:0]   dat_o,
    output logic                ack_o
);
    logic              beat_done;
    logic [ADDR_W-1:0] beat_addr;
    logic [DATA_W-1:0] rd_word;
    logic              store_wr;

    burst_beat_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc       (cyc_i),
        .stb       (stb_i),
        .adr       (adr_i),
        .cti       (cti_i),
        .ack       (ack_o),
        .beat_done (beat_done),
        .beat_addr (beat_addr)
    );

    burst_word_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (store_wr),
        .addr     (beat_addr),
        .wr_data  (dat_i),
        .wr_lanes (sel_i),
        .rd_data  (rd_word)
    );

    // Write only on completed beats; drive data only while acknowledging.
    always_comb begin
        store_wr = beat_done & we_i;
        dat_o    = ack_o ? rd_word : '0;
    end

endmodule

// File: rtl/bus_burst_slave_chk.sv
// Protocol checker for the burst memory slave, bound to the top module.
module bus_burst_slave_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_i,
    input logic              stb_i,
    input logic              we_i,
    input logic [2:0]        cti_i,
    input logic [DATA_W-1:0] dat_o,
    input logic              ack_o
);
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o |-> dat_o == '0); // R1
    AST_FIRST_BEAT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i && stb_i && !ack_o) |=> ack_o); // R2
    AST_NO_UNASKED_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_o && !(cyc_i && stb_i)) |=> !ack_o); // R2
    AST_END_DROPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i && stb_i && ack_o && cti_i != 3'b001 && cti_i != 3'b010) |=> !ack_o); // R3
    AST_INCR_KEEPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i && stb_i && ack_o && cti_i == 3'b010) |=> ack_o); // R4
    AST_FIXED_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i && stb_i && ack_o && !we_i && cti_i == 3'b001) |=> (ack_o && $stable(dat_o))); // R5
    AST_WAIT_HOLDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i && !stb_i && ack_o) |=> (ack_o && $stable(dat_o))); // R6
    AST_CYC_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_i |=> !ack_o); // R7
endmodule

bind bus_burst_slave bus_burst_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cyc_i (cyc_i),
    .stb_i (stb_i),
    .we_i  (we_i),
    .cti_i (cti_i),
    .dat_o (dat_o),
    .ack_o (ack_o)
);

// File: tb/test_bus_burst_slave.sv
module test_bus_burst_slave;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [AW-1:0] adr = '0;
    logic [DW-1:0] wdat = '0;
    logic [3:0]    sel = '0;
    logic [2:0]    cti = 3'b000;
    logic [DW-1:0] rdat;
    logic          ack;

    logic [DW-1:0] model [DEPTH];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bus_burst_slave #(.DATA_W(DW), .ADDR_W(AW)) i_bus_burst_slave (
        .clk(clk), .rst_n(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we),
        .adr_i(adr), .dat_i(wdat), .sel_i(sel), .cti_i(cti),
        .dat_o(rdat), .ack_o(ack)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cyc = 0; stb = 0; we = 0; cti = 3'b000; sel = '0;
    endtask

    task automatic merge(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] s);
        for (int b = 0; b < 4; b++) begin
            if (s[b]) model[a][b*8 +: 8] = d[b*8 +: 8];
        end
    endtask

    task automatic wr_single(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] s);
        cyc = 1; stb = 1; we = 1; adr = a; wdat = d; sel = s; cti = 3'b000;
        tick();
        check(ack === 1'b1, "R2 write ack latency", DW'(ack), 1);
        tick();
        check(ack === 1'b0, "R3 single write ack drop", DW'(ack), 0);
        merge(a, d, s);
        idle();
    endtask

    task automatic rd_single(input logic [AW-1:0] a, input string tag);
        cyc = 1; stb = 1; we = 0; adr = a; cti = 3'b000;
        tick();
        check(ack === 1'b1, "R2 read ack latency", DW'(ack), 1);
        check(rdat === model[a], tag, rdat, model[a]);
        tick();
        check(ack === 1'b0, "R3 single read ack drop", DW'(ack), 0);
        idle();
    endtask

    task automatic t_reset();
        check(ack === 1'b0, "R1 ack after reset", DW'(ack), 0);
        check(rdat === '0, "R1 data zero after reset", rdat, 0);
    endtask

    task automatic t_preload();
        for (int i = 0; i < DEPTH; i++) begin
            wr_single(AW'(i), 32'hA500_0000 | (i * 32'h0001_0203), 4'hF);
        end
        rd_single(4'd3, "R2 single read data");
        rd_single(4'd11, "R2 single read data other word");
    endtask

    task automatic t_incr_wait();
        cyc = 1; stb = 1; we = 0; adr = 4'd2; cti = 3'b010;
        tick();
        check(ack === 1'b1, "R2 burst first ack", DW'(ack), 1);
        check(rdat === model[2], "R2 burst first data", rdat, model[2]);
        tick();
        check(ack === 1'b1, "R4 incr keeps ack", DW'(ack), 1);
        check(rdat === model[3], "R4 incr next word", rdat, model[3]);
        adr = 4'd3; stb = 0;
        tick();
        check(ack === 1'b1, "R6 wait keeps ack", DW'(ack), 1);
        check(rdat === model[3], "R6 wait holds word", rdat, model[3]);
        stb = 1;
        tick();
        check(rdat === model[4], "R4 resume advances once", rdat, model[4]);
        adr = 4'd4;
        tick();
        check(rdat === model[5], "R4 incr third step", rdat, model[5]);
        adr = 4'd5; cti = 3'b111;
        tick();
        check(ack === 1'b0, "R3 last beat drops ack", DW'(ack), 0);
        check(rdat === '0, "R1 data zero when idle", rdat, 0);
        idle();
    endtask

    task automatic t_wrap();
        cyc = 1; stb = 1; we = 0; adr = 4'd15; cti = 3'b010;
        tick();
        check(rdat === model[15], "R4 top word", rdat, model[15]);
        tick();
        check(rdat === model[0], "R4 address wraps", rdat, model[0]);
        adr = 4'd0; cti = 3'b111;
        tick();
        check(ack === 1'b0, "R3 wrap burst end", DW'(ack), 0);
        idle();
    endtask

    task automatic t_fixed();
        cyc = 1; stb = 1; we = 1; adr = 4'd7; cti = 3'b001; sel = 4'hF; wdat = 32'h1111_2222;
        tick();
        tick();
        check(ack === 1'b1, "R5 fixed keeps ack", DW'(ack), 1);
        merge(4'd7, 32'h1111_2222, 4'hF);
        stb = 0; wdat = 32'hBBBB_BBBB;
        tick();
        check(ack === 1'b1, "R6 write wait keeps ack", DW'(ack), 1);
        stb = 1; wdat = 32'h3333_4444; sel = 4'b0011; cti = 3'b111;
        tick();
        check(ack === 1'b0, "R3 fixed write end", DW'(ack), 0);
        merge(4'd7, 32'h3333_4444, 4'b0011);
        idle();
        rd_single(4'd7, "R6 stalled write not stored");
        cyc = 1; stb = 1; we = 0; adr = 4'd7; cti = 3'b001;
        tick();
        tick();
        check(ack === 1'b1, "R5 fixed read ack", DW'(ack), 1);
        check(rdat === model[7], "R5 fixed read same word", rdat, model[7]);
        cti = 3'b111;
        tick();
        check(ack === 1'b0, "R3 fixed read end", DW'(ack), 0);
        idle();
    endtask

    task automatic t_cyc_drop();
        cyc = 1; stb = 1; we = 0; adr = 4'd9; cti = 3'b010;
        tick();
        check(ack === 1'b1, "R7 ack before drop", DW'(ack), 1);
        idle();
        tick();
        check(ack === 1'b0, "R7 cyc low clears ack", DW'(ack), 0);
        check(rdat === '0, "R7 data cleared", rdat, 0);
        rd_single(4'd12, "R7 fresh request after drop");
    endtask

    task automatic t_lanes();
        wr_single(4'd5, 32'hDEAD_BEEF, 4'b0101);
        rd_single(4'd5, "R8 byte lanes merged");
        wr_single(4'd6, 32'hCAFE_F00D, 4'b1000);
        rd_single(4'd6, "R8 top lane only");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        cyc = 1; stb = 1;
        repeat (3) tick();
        idle();
        rst_n = 1;
        tick();
        t_reset();
        t_preload();
        t_incr_wait();
        t_wrap();
        t_fixed();
        t_cyc_drop();
        t_lanes();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule